// File: doc/BRIEF.md
# Cache Line Policy Sampler

This block fixes two configuration straps while hard reset is asserted, then classifies every cache line fill as write-back or write-through. The Upgrade Present strap is active low. If it reads low on the last reset clock, the block asks the pads to float. The write-back strap picks the global cache mode. In write-back mode, the same input is read again once per line fill, on the first ready of that fill, and the result is the policy of the line. If the strap read low at reset, every fill is reported as write-through.

Reset is synchronous and active high. The straps are copied on every clock while reset is high. The falling edge of reset is found with a registered copy of reset, and on that edge the last copy is committed. A soft reset clears the fill tracking only. It never re-reads either strap.

Top module: `cache_policy_sampler`

## Requirements
- R1: The Upgrade Present strap is taken from the last clock edge on which `rst` is high. Levels seen earlier in reset, or at any time after reset, do not set `tri_en`.
- R2: If that sample is low, `tri_en` is high from the first edge after reset falls, for as long as `upgrade_n` stays low. The first time `upgrade_n` is high, `tri_en` drops in the same cycle, and it stays low until the next hard reset.
- R3: `wb_mode` is 0 during hard reset. From the first edge after reset falls, it equals the `wbwt` level sampled on the last reset-high edge, and it holds that value until the next hard reset.
- R4: While `wb_mode` is 0, every fill strobe carries `fill_wb` = 0, whatever `wbwt` is.
- R5: While `wb_mode` is 1, the first edge of a fill on which `rdy` or `brdy` is high samples `wbwt`. After that edge, `fill_vld` is 1 for exactly one cycle and `fill_wb` equals the sampled level (1 = write-back, 0 = write-through).
- R6: Further `rdy` or `brdy` beats of the same fill raise no strobe and leave `fill_wb` unchanged.
- R7: A fill ends when `fill_active` is low, and a new one begins with `burst_start`. A ready on the same edge as `burst_start` is the first ready of the new fill.
- R8: `soft_rst` clears the fill tracking, `fill_vld` and `fill_wb` after the edge. `wb_mode` and `tri_en` are unchanged, and the next ready after `soft_rst` is treated as a first ready.
- R9: While `tri_en` is high, no `fill_vld` strobe is produced.
- R10: During hard reset, and on the edge on which reset falls, `fill_vld` and `tri_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, active high, synchronous |
| soft_rst | input | 1 | Soft reset, clears fill tracking only |
| upgrade_n | input | 1 | Upgrade Present strap, active low |
| wbwt | input | 1 | Write-back / write-through strap and per-line policy |
| fill_active | input | 1 | A cache line fill is in progress |
| rdy | input | 1 | Single-transfer ready |
| brdy | input | 1 | Burst ready |
| burst_start | input | 1 | Marks the first cycle of a new fill |
| tri_en | output | 1 | Request to float all outputs |
| wb_mode | output | 1 | Global write-back mode |
| fill_wb | output | 1 | Policy of the last classified line, 1 = write-back |
| fill_vld | output | 1 | One-cycle strobe for `fill_wb` |

## Verification
A strap committed on the wrong edge shows at the ports in the first cycle after reset falls, as a wrong `wb_mode` or `tri_en` level. A fill tracker that never arms, or never disarms, shows as a missing or extra `fill_vld` one cycle after the ready beat concerned. The stimulus covers back-to-back fills, a soft reset in the middle of a burst, and straps that change in the last reset cycle, so each wrong state appears within a cycle or two.

// File: rtl/cps_pkg.sv
package cps_pkg;
   typedef struct packed {
      logic up_n;
      logic wb;
   } strap_t;

   localparam int unsigned POLICY_KEEP  = 0;
   localparam int unsigned POLICY_CLEAR = 1;
endpackage

// File: rtl/cps_strap_latch.sv
module cps_strap_latch
   import cps_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic upgrade_n,
   input  logic wbwt,
   output logic wb_mode,
   output logic tri_en,
   output logic commit_cyc
);
   strap_t shadow_q;
   logic   rst_q;
   logic   up_hold_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow_q  <= '{up_n: upgrade_n, wb: wbwt};
         rst_q     <= 1'b1;
         wb_mode   <= 1'b0;
         up_hold_q <= 1'b0;
      end else begin
         rst_q <= 1'b0;
         if (rst_q) begin
            wb_mode   <= shadow_q.wb;
            up_hold_q <= ~shadow_q.up_n;
         end else if (upgrade_n) begin
            up_hold_q <= 1'b0;
         end
      end
   end

   assign tri_en     = up_hold_q & ~upgrade_n;
   assign commit_cyc = rst_q;

   // R3
   wb_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst_q && !$past(rst_q)) |-> $stable(wb_mode));

   // R2
   tri_no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst_q && !tri_en) |=> !tri_en);

   // R10
   tri_in_reset_chk: assert property (@(posedge clk) rst |-> !tri_en);
endmodule

// File: rtl/cps_fill_tracker.sv
module cps_fill_tracker
   import cps_pkg::*;
#(
   parameter int unsigned POLICY_CLEAR_MODE = POLICY_CLEAR
)(
   input  logic clk,
   input  logic rst,
   input  logic soft_rst,
   input  logic block,
   input  logic wb_mode,
   input  logic fill_active,
   input  logic rdy,
   input  logic brdy,
   input  logic burst_start,
   input  logic wbwt,
   output logic fill_wb,
   output logic fill_vld
);
   logic taken_q;
   logic any_ready;
   logic armed;
   logic hit;
   logic clr;

   assign any_ready = rdy | brdy;
   assign armed     = burst_start | ~taken_q;
   assign hit       = fill_active & any_ready & armed & ~block;
   assign clr       = rst | soft_rst;

   always_ff @(posedge clk) begin
      if (clr || !fill_active) begin
         taken_q <= 1'b0;
      end else begin
         taken_q <= (taken_q & ~burst_start) | any_ready;
      end
   end

   always_ff @(posedge clk) begin
      if (clr) fill_vld <= 1'b0;
      else     fill_vld <= hit;
   end

   generate
      if (POLICY_CLEAR_MODE == POLICY_CLEAR) begin : g_pol_clear
         always_ff @(posedge clk) begin
            if (clr)      fill_wb <= 1'b0;
            else if (hit) fill_wb <= wb_mode & wbwt;
         end
      end else if (POLICY_CLEAR_MODE == POLICY_KEEP) begin : g_pol_keep
         always_ff @(posedge clk) begin
            if (rst)      fill_wb <= 1'b0;
            else if (hit && !soft_rst) fill_wb <= wb_mode & wbwt;
         end
      end else begin : g_pol_bad
         $error("cps_fill_tracker: POLICY_CLEAR_MODE must be 0 or 1");
      end
   endgenerate

   // R6
   no_resample_chk: assert property (@(posedge clk) disable iff (rst)
      (taken_q && fill_active && !burst_start) |=> !fill_vld);

   // R8
   soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
      soft_rst |=> !fill_vld);

   // R10
   vld_reset_chk: assert property (@(posedge clk) rst |=> !fill_vld);
endmodule

// File: rtl/cache_policy_sampler.sv
module cache_policy_sampler
   import cps_pkg::*;
#(
   parameter int unsigned POLICY_CLEAR_MODE = POLICY_CLEAR
)(
   input  logic clk,
   input  logic rst,
   input  logic soft_rst,
   input  logic upgrade_n,
   input  logic wbwt,
   input  logic fill_active,
   input  logic rdy,
   input  logic brdy,
   input  logic burst_start,
   output logic tri_en,
   output logic wb_mode,
   output logic fill_wb,
   output logic fill_vld
);
   logic commit_cyc;
   logic block;

   cps_strap_latch u_strap (
      .clk        (clk),
      .rst        (rst),
      .upgrade_n  (upgrade_n),
      .wbwt       (wbwt),
      .wb_mode    (wb_mode),
      .tri_en     (tri_en),
      .commit_cyc (commit_cyc)
   );

   assign block = tri_en | commit_cyc;

   cps_fill_tracker #(
      .POLICY_CLEAR_MODE (POLICY_CLEAR_MODE)
   ) u_fill (
      .clk         (clk),
      .rst         (rst),
      .soft_rst    (soft_rst),
      .block       (block),
      .wb_mode     (wb_mode),
      .fill_active (fill_active),
      .rdy         (rdy),
      .brdy        (brdy),
      .burst_start (burst_start),
      .wbwt        (wbwt),
      .fill_wb     (fill_wb),
      .fill_vld    (fill_vld)
   );

   // R4
   wt_only_chk: assert property (@(posedge clk) disable iff (rst)
      (!wb_mode && fill_vld) |-> !fill_wb);

   // R9
   tri_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      tri_en |-> !fill_vld);
endmodule

// File: tb/cache_policy_sampler_tb.sv
`timescale 1ns/1ps
module cache_policy_sampler_tb;
   logic clk = 1'b0;
   logic rst = 1'b1, soft_rst = 1'b0, upgrade_n = 1'b1, wbwt = 1'b0;
   logic fill_active = 1'b0, rdy = 1'b0, brdy = 1'b0, burst_start = 1'b0;
   logic tri_en, wb_mode, fill_wb, fill_vld;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   cache_policy_sampler u_dut (
      .clk(clk), .rst(rst), .soft_rst(soft_rst), .upgrade_n(upgrade_n),
      .wbwt(wbwt), .fill_active(fill_active), .rdy(rdy), .brdy(brdy),
      .burst_start(burst_start), .tri_en(tri_en), .wb_mode(wb_mode),
      .fill_wb(fill_wb), .fill_vld(fill_vld)
   );

   // {fill, rdy, brdy, burst_start, wbwt, exp_vld, exp_wb}
   localparam logic [6:0] VEC [12] = '{
      7'b1001100, 7'b1010111, 7'b1010001, 7'b1010001,
      7'b0000001, 7'b1011010, 7'b1010100, 7'b0100100,
      7'b1100111, 7'b0000001, 7'b1100010, 7'b1011111
   };

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic drive(input logic f, input logic r, input logic b,
                        input logic s, input logic w);
      fill_active = f; rdy = r; brdy = b; burst_start = s; wbwt = w;
   endtask

   task automatic do_reset(input logic up_early, input logic up_last, input logic wb);
      @(negedge clk);
      rst = 1'b1; soft_rst = 1'b0; upgrade_n = up_early;
      drive(0, 0, 0, 0, wb);
      repeat (2) @(negedge clk);
      check("R10 vld in reset", fill_vld, 1'b0);
      check("R10 tri in reset", tri_en, 1'b0);
      check("R3 mode in reset", wb_mode, 1'b0);
      upgrade_n = up_last;
      @(negedge clk);
      rst = 1'b0;
      wbwt = ~wb;
      @(negedge clk);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset(1'b1, 1'b1, 1'b1);
      check("R3 mode latched high", wb_mode, 1'b1);
      check("R10 no vld on release", fill_vld, 1'b0);
      wbwt = 1'b0;
      @(negedge clk);
      check("R3 mode holds", wb_mode, 1'b1);

      foreach (VEC[i]) begin
         drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
         @(negedge clk);
         check($sformatf("R5 R6 R7 vec%0d vld", i), fill_vld, VEC[i][1]);
         check($sformatf("R5 R6 R7 vec%0d wb", i), fill_wb, VEC[i][0]);
      end
      drive(0, 0, 0, 0, 0);
      @(negedge clk);
      check("R5 single pulse", fill_vld, 1'b0);

      // R8: soft reset in the middle of a burst
      drive(1, 0, 1, 1, 1);
      @(negedge clk);
      check("R8 pre vld", fill_vld, 1'b1);
      soft_rst = 1'b1; drive(1, 0, 1, 0, 1);
      @(negedge clk);
      check("R8 vld cleared", fill_vld, 1'b0);
      check("R8 wb cleared", fill_wb, 1'b0);
      check("R8 mode kept", wb_mode, 1'b1);
      soft_rst = 1'b0; drive(1, 0, 1, 0, 1);
      @(negedge clk);
      check("R8 rearmed vld", fill_vld, 1'b1);
      check("R8 rearmed wb", fill_wb, 1'b1);
      drive(0, 0, 0, 0, 0);

      // R4: write-through mode
      do_reset(1'b1, 1'b1, 1'b0);
      check("R3 mode latched low", wb_mode, 1'b0);
      drive(1, 1, 0, 1, 1);
      @(negedge clk);
      check("R4 vld", fill_vld, 1'b1);
      check("R4 forced wt", fill_wb, 1'b0);
      drive(0, 0, 0, 0, 0);

      // R2 / R9: upgrade strap low
      do_reset(1'b0, 1'b0, 1'b1);
      check("R2 tri set", tri_en, 1'b1);
      drive(1, 1, 0, 1, 1);
      @(negedge clk);
      check("R9 vld blocked", fill_vld, 1'b0);
      check("R2 tri held", tri_en, 1'b1);
      drive(0, 0, 0, 0, 0);
      upgrade_n = 1'b1;
      #1;
      check("R2 tri drops at once", tri_en, 1'b0);
      @(negedge clk);
      upgrade_n = 1'b0;
      @(negedge clk);
      check("R2 tri stays off", tri_en, 1'b0);

      // R1: only the last reset clock counts
      do_reset(1'b0, 1'b1, 1'b1);
      upgrade_n = 1'b0;
      #1;
      check("R1 early low ignored", tri_en, 1'b0);
      @(negedge clk);
      check("R1 run low ignored", tri_en, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule